// File: doc/BRIEF.md
# Debug Breakpoint Qualification Unit

This unit decides when debug events become a breakpoint request to a processor core. It receives single-cycle match pulses from watchpoint comparators and breakpoint requests from outside the core. An external request can come from any on-chip peripheral or from a debug host. The core supplies a restart-safe status bit. Trap-enable bits reach the unit from two writers: software and a serial debug port.

Each internal source is a watchpoint match or the expiry of an occurrence counter. Each has a mode bit. In masked mode (the default) a source is honoured only while the core reports a restartable state. A masked event that arrives while the core is not restartable is held pending. It is issued on the first cycle the state becomes restartable again, unless software drops it first. In non-masked mode the source is honoured at once.

Watchpoint matches are always echoed on the watchpoint pins as pulses. The occurrence counters count down on watchpoint matches. A counter stops counting while its own source is in masked mode and the core is not restartable. Counter `i` counts watchpoint `i`, so `NUM_CNT` must not exceed `NUM_WP`. The core sees a level request that holds until it acknowledges.

Top module: `dbg_bkpt_qual`

## Requirements
- R1: Internal source `s` is enabled when bit `s` of the software enable register or bit `s` of the debug-port enable register is 1. A source with neither bit set never raises `bkpt_req`. Sources `0..NUM_WP-1` are watchpoints `0..NUM_WP-1`. Sources `NUM_WP+i` are the expiries of counter `i`.
- R2: A source in masked mode (its mode bit 0) that is enabled and has an event while `core_ri`=1 raises `bkpt_req` on the following cycle. With `core_ri`=0 the event raises nothing in that cycle.
- R3: A masked event seen while `core_ri`=0 is held pending. The pending event fires in the first cycle with `core_ri`=1, and `bkpt_req` rises on the cycle after. A `pend_clr` pulse drops every pending event, and it wins over a `core_ri` return in the same cycle.
- R4: A source whose mode bit is 1 (non-masked) raises `bkpt_req` on the following cycle whatever the value of `core_ri`.
- R5: `ext_bkpt` is maskable and needs no enable: it follows R2 and R3. `ext_bkpt_nm` raises `bkpt_req` on the following cycle even when `core_ri`=0.
- R6: `wp_out` equals `wp_in` delayed by one cycle, whatever the values of `core_ri`, the enables and the modes.
- R7: A pulse on `cnt_load[i]` loads counter `i` with `cnt_load_val`. Each `wp_in[i]` pulse decrements a nonzero counter. The step from 1 to 0 is an event of source `NUM_WP+i`. A counter at 0 stays at 0 and produces no further events.
- R8: Counter `i` does not decrement while mode bit `NUM_WP+i` is 0 and `core_ri`=0.
- R9: `bkpt_req` stays high until a cycle with `bkpt_ack`=1 and then falls. If a new breakpoint fires in the acknowledge cycle, `bkpt_req` stays high.
- R10: Synchronous `rst` clears `bkpt_req`, `wp_out`, all pending events, all counters, both enable registers and all mode bits, so every source starts in masked mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Write strobe for the software enable register |
| sw_en_data | input | NUM_WP+NUM_CNT | Software enable value |
| dp_wr | input | 1 | Write strobe for the debug-port enable register |
| dp_en_data | input | NUM_WP+NUM_CNT | Debug-port enable value |
| nm_wr | input | 1 | Write strobe for the mode register |
| nm_data | input | NUM_WP+NUM_CNT | Mode bits, 1 = non-masked |
| cnt_load | input | NUM_CNT | Per-counter load strobes |
| cnt_load_val | input | CNT_W | Counter start value |
| wp_in | input | NUM_WP | Watchpoint match pulses |
| ext_bkpt | input | 1 | Maskable external breakpoint request |
| ext_bkpt_nm | input | 1 | Non-maskable external breakpoint request |
| core_ri | input | 1 | Core restartable-state bit |
| pend_clr | input | 1 | Drops all pending masked events |
| bkpt_ack | input | 1 | Core acknowledge of the breakpoint request |
| bkpt_req | output | 1 | Breakpoint request level to the core |
| wp_out | output | NUM_WP | Watchpoint indication pulses |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a pending masked event meets the return of `core_ri` in the same cycle as a software `pend_clr`. The bench raises both inputs in one cycle and expects `bkpt_req` to stay low afterwards. In the second, the core acknowledges in the same cycle that a non-maskable external request arrives. The bench drives both in one cycle and expects `bkpt_req` to remain high, then fall after a lone acknowledge. The counter's final decrement and the watchpoint pulse it counts also share a cycle. The bench checks that the request rises exactly on the cycle after the last counted match.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  typedef enum logic {
    MODE_MASKED    = 1'b0,
    MODE_NONMASKED = 1'b1
  } src_mode_e;

  // A source may act now if it ignores masking or the core is restartable.
  function automatic logic src_open(input logic nonmask, input logic ri);
    return nonmask | ri;
  endfunction
endpackage

// File: rtl/dbg_wp_counter.sv
module dbg_wp_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  assign expire = step && !load && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (step && cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(cnt)); // R8
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> (cnt == '0)); // R7
  AST_CNT_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == '0)); // R7
endmodule

// File: rtl/dbg_src_gate.sv
module dbg_src_gate
  import dbg_bkpt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic event_in,
  input  logic nonmask,
  input  logic ri,
  input  logic clr,
  output logic fire
);
  logic pend;
  logic open_now;

  assign open_now = src_open(nonmask, ri);
  assign fire = (event_in && open_now) || (pend && ri && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else begin
      pend <= (pend && !clr && !ri) || (event_in && !open_now);
    end
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ri && !nonmask) |-> !fire); // R2
  AST_PEND_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (pend && ri && !clr) |-> fire); // R3
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && !event_in) |=> !pend); // R3
endmodule

// File: rtl/dbg_bkpt_qual.sv
module dbg_bkpt_qual
  import dbg_bkpt_pkg::*;
#(
  parameter int NUM_WP  = 4,
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 8,
  localparam int NSRC   = NUM_WP + NUM_CNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_wr,
  input  logic [NSRC-1:0]    sw_en_data,
  input  logic               dp_wr,
  input  logic [NSRC-1:0]    dp_en_data,
  input  logic               nm_wr,
  input  logic [NSRC-1:0]    nm_data,
  input  logic [NUM_CNT-1:0] cnt_load,
  input  logic [CNT_W-1:0]   cnt_load_val,
  input  logic [NUM_WP-1:0]  wp_in,
  input  logic               ext_bkpt,
  input  logic               ext_bkpt_nm,
  input  logic               core_ri,
  input  logic               pend_clr,
  input  logic               bkpt_ack,
  output logic               bkpt_req,
  output logic [NUM_WP-1:0]  wp_out
);
  logic [NSRC-1:0]    sw_en_q;
  logic [NSRC-1:0]    dp_en_q;
  logic [NSRC-1:0]    nm_q;
  logic [NSRC-1:0]    src_event;
  logic [NSRC-1:0]    src_fire;
  logic [NUM_CNT-1:0] cnt_expire;
  logic               ext_fire;
  logic               fire_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en_q <= '0;
      dp_en_q <= '0;
      nm_q    <= {NSRC{MODE_MASKED}};
    end else begin
      if (sw_wr) sw_en_q <= sw_en_data;
      if (dp_wr) dp_en_q <= dp_en_data;
      if (nm_wr) nm_q    <= nm_data;
    end
  end

  assign src_event[NUM_WP-1:0] = wp_in;

  for (genvar ci = 0; ci < NUM_CNT; ci++) begin : g_cnt
    logic cnt_step;
    assign cnt_step = wp_in[ci] && src_open(nm_q[NUM_WP+ci], core_ri);
    dbg_wp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (cnt_load[ci]),
      .load_val (cnt_load_val),
      .step     (cnt_step),
      .expire   (cnt_expire[ci])
    );
    assign src_event[NUM_WP+ci] = cnt_expire[ci];
  end

  for (genvar si = 0; si < NSRC; si++) begin : g_src
    logic enabled;
    assign enabled = sw_en_q[si] | dp_en_q[si];
    dbg_src_gate u_gate (
      .clk      (clk),
      .rst      (rst),
      .event_in (src_event[si] && enabled),
      .nonmask  (nm_q[si]),
      .ri       (core_ri),
      .clr      (pend_clr),
      .fire     (src_fire[si])
    );
  end

  dbg_src_gate u_ext_gate (
    .clk      (clk),
    .rst      (rst),
    .event_in (ext_bkpt),
    .nonmask  (1'b0),
    .ri       (core_ri),
    .clr      (pend_clr),
    .fire     (ext_fire)
  );

  assign fire_any = (|src_fire) || ext_fire || ext_bkpt_nm;

  always_ff @(posedge clk) begin
    if (rst) begin
      bkpt_req <= 1'b0;
      wp_out   <= '0;
    end else begin
      bkpt_req <= fire_any || (bkpt_req && !bkpt_ack);
      wp_out   <= wp_in;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bkpt_req && !bkpt_ack) |=> bkpt_req); // R9
  AST_REQ_SET: assert property (@(posedge clk) disable iff (rst)
    fire_any |=> bkpt_req); // R2
  AST_NM_EXT: assert property (@(posedge clk) disable iff (rst)
    ext_bkpt_nm |=> bkpt_req); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (bkpt_ack && !fire_any) |=> !bkpt_req); // R9
endmodule

// File: tb/dbg_bkpt_qual_bench.sv
module dbg_bkpt_qual_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_WP = 4;
  localparam int NUM_CNT = 2;
  localparam int CNT_W = 8;
  localparam int NSRC = NUM_WP + NUM_CNT;
  localparam int NVEC = 8;
  // {sw[6], dp[6], nm[6], wp[4], ri, expected_req}
  localparam logic [23:0] VEC [NVEC] = '{
    {6'b000001, 6'b000000, 6'b000000, 4'b0001, 1'b1, 1'b1},
    {6'b000000, 6'b000010, 6'b000000, 4'b0010, 1'b1, 1'b1},
    {6'b000000, 6'b000000, 6'b000000, 4'b0001, 1'b1, 1'b0},
    {6'b000100, 6'b000000, 6'b000000, 4'b1000, 1'b1, 1'b0},
    {6'b001000, 6'b000000, 6'b001000, 4'b1000, 1'b0, 1'b1},
    {6'b000001, 6'b000000, 6'b000000, 4'b0001, 1'b0, 1'b0},
    {6'b000000, 6'b000001, 6'b000001, 4'b0001, 1'b0, 1'b1},
    {6'b000011, 6'b000000, 6'b000000, 4'b0011, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_wr = 1'b0, dp_wr = 1'b0, nm_wr = 1'b0;
  logic [NSRC-1:0] sw_en_data = '0, dp_en_data = '0, nm_data = '0;
  logic [NUM_CNT-1:0] cnt_load = '0;
  logic [CNT_W-1:0] cnt_load_val = '0;
  logic [NUM_WP-1:0] wp_in = '0;
  logic ext_bkpt = 1'b0, ext_bkpt_nm = 1'b0, core_ri = 1'b1;
  logic pend_clr = 1'b0, bkpt_ack = 1'b0;
  logic bkpt_req;
  logic [NUM_WP-1:0] wp_out;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_bkpt_qual #(.NUM_WP(NUM_WP), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_dbg_bkpt_qual (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_en_data(sw_en_data),
    .dp_wr(dp_wr), .dp_en_data(dp_en_data), .nm_wr(nm_wr), .nm_data(nm_data),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .wp_in(wp_in),
    .ext_bkpt(ext_bkpt), .ext_bkpt_nm(ext_bkpt_nm), .core_ri(core_ri),
    .pend_clr(pend_clr), .bkpt_ack(bkpt_ack), .bkpt_req(bkpt_req), .wp_out(wp_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [NSRC-1:0] sw, input logic [NSRC-1:0] dp,
                           input logic [NSRC-1:0] nm);
    sw_en_data = sw; dp_en_data = dp; nm_data = nm;
    sw_wr = 1'b1; dp_wr = 1'b1; nm_wr = 1'b1;
    step();
    sw_wr = 1'b0; dp_wr = 1'b0; nm_wr = 1'b0;
  endtask

  task automatic flush();
    bkpt_ack = 1'b1; pend_clr = 1'b1; core_ri = 1'b1;
    step();
    bkpt_ack = 1'b0; pend_clr = 1'b0;
    step();
  endtask

  task automatic pulse_wp(input logic [NUM_WP-1:0] w);
    wp_in = w;
    step();
    wp_in = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    repeat (3) step();
    check("R10 reset req", {7'b0, bkpt_req}, 8'd0);
    check("R10 reset wp_out", {4'b0, wp_out}, 8'd0);
    rst = 1'b0;
    step();

    // Vector table: enable OR, masking, non-masked mode, watchpoint echo.
    for (int v = 0; v < NVEC; v++) begin
      write_cfg(VEC[v][23:18], VEC[v][17:12], VEC[v][11:6]);
      core_ri = VEC[v][1];
      pulse_wp(VEC[v][5:2]);
      check($sformatf("R1 R2 R4 vector %0d req", v), {7'b0, bkpt_req}, {7'b0, VEC[v][0]});
      check($sformatf("R6 vector %0d wp_out", v), {4'b0, wp_out}, {4'b0, VEC[v][5:2]});
      flush();
    end

    // R10: reset clears mode bits, so a fresh enable is masked.
    write_cfg(6'b000001, 6'b000000, 6'b000001);
    rst = 1'b1; step(); rst = 1'b0;
    check("R10 req after reset", {7'b0, bkpt_req}, 8'd0);
    sw_en_data = 6'b000001; sw_wr = 1'b1; step(); sw_wr = 1'b0;
    core_ri = 1'b0;
    pulse_wp(4'b0001);
    check("R10 masked default", {7'b0, bkpt_req}, 8'd0);
    step(); step();
    check("R3 pending held", {7'b0, bkpt_req}, 8'd0);
    core_ri = 1'b1;
    step();
    check("R3 pending issued on ri return", {7'b0, bkpt_req}, 8'd1);
    flush();

    // R3: pend_clr while ri is 0 drops the event.
    core_ri = 1'b0;
    pulse_wp(4'b0001);
    pend_clr = 1'b1; step(); pend_clr = 1'b0;
    core_ri = 1'b1; step();
    check("R3 cleared pending", {7'b0, bkpt_req}, 8'd0);

    // R3: pend_clr in the same cycle as ri return wins.
    core_ri = 1'b0;
    pulse_wp(4'b0001);
    core_ri = 1'b1; pend_clr = 1'b1; step(); pend_clr = 1'b0;
    step();
    check("R3 clear wins over ri return", {7'b0, bkpt_req}, 8'd0);
    flush();

    // R5: external maskable and non-maskable.
    core_ri = 1'b0;
    ext_bkpt = 1'b1; step(); ext_bkpt = 1'b0;
    check("R5 maskable ext blocked", {7'b0, bkpt_req}, 8'd0);
    core_ri = 1'b1; step();
    check("R5 maskable ext pending issued", {7'b0, bkpt_req}, 8'd1);
    flush();
    core_ri = 1'b0;
    ext_bkpt_nm = 1'b1; step(); ext_bkpt_nm = 1'b0;
    check("R5 non-maskable ext", {7'b0, bkpt_req}, 8'd1);

    // R9: level hold, ack, fire in ack cycle.
    step(); step();
    check("R9 request held", {7'b0, bkpt_req}, 8'd1);
    bkpt_ack = 1'b1; ext_bkpt_nm = 1'b1; step(); ext_bkpt_nm = 1'b0;
    check("R9 fire with ack keeps req", {7'b0, bkpt_req}, 8'd1);
    step(); bkpt_ack = 1'b0;
    check("R9 ack drops req", {7'b0, bkpt_req}, 8'd0);
    core_ri = 1'b1;
    flush();

    // R7: counter 0 loaded with 3 expires on the third wp0 match.
    write_cfg(6'b010000, 6'b000000, 6'b000000);
    cnt_load_val = 8'd3; cnt_load = 2'b01; step(); cnt_load = '0;
    pulse_wp(4'b0001); pulse_wp(4'b0001);
    check("R7 no event before zero", {7'b0, bkpt_req}, 8'd0);
    pulse_wp(4'b0001);
    check("R7 expiry event", {7'b0, bkpt_req}, 8'd1);
    flush();
    pulse_wp(4'b0001);
    check("R7 stays at zero", {7'b0, bkpt_req}, 8'd0);
    flush();

    // R8: counter 1 frozen while masked and ri is 0.
    write_cfg(6'b100000, 6'b000000, 6'b000000);
    cnt_load_val = 8'd2; cnt_load = 2'b10; step(); cnt_load = '0;
    core_ri = 1'b0;
    pulse_wp(4'b0010);
    check("R6 wp_out with ri low", {4'b0, wp_out}, 8'h02);
    pulse_wp(4'b0010); pulse_wp(4'b0010);
    core_ri = 1'b1;
    pulse_wp(4'b0010);
    check("R8 count frozen", {7'b0, bkpt_req}, 8'd0);
    pulse_wp(4'b0010);
    check("R8 expiry after thaw", {7'b0, bkpt_req}, 8'd1);
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule